// File: doc/BRIEF.md
# Dual-Table Four-Lane Huffman Block Decoder

This block takes one compressed 128-byte block, carried in as thirty-two 32-bit words, and decodes it back into 64 symbols of 16 bits each. The block opens with a short header. Bit 0 is a mode flag that selects lossless or lossy decoding. Three 7-bit byte pointers follow it. They mark where the second, third and fourth sub-streams begin. The first sub-stream starts right after the header. Four decode lanes then run in lock-step, each producing one symbol per cycle. The decoded symbols are emitted in their original order.

Two decode banks hold the code tables. Bank 0 holds exact symbols and bank 1 holds quantized symbols. The mode flag latched from the header steers every lane to one of the two banks. Each bank is a small content-matched table, written through a plain write port before any block that uses it arrives. Symbols taken from the lossy bank come out with their low `Q_BITS` bits forced to zero.

The compressed input is a valid/ready stream, and so is the symbol output. The input is ready only while a block is being loaded. The output holds each symbol until the consumer takes it. A one-cycle `done` pulse marks the end of each block.

Top module: `mhd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: A block is exactly 32 input words. A word moves on any clock edge where `in_valid` and `in_ready` are both high. After the 32nd word moves, `in_ready` goes low until the block has been fully emitted.
- R3: Block bit b is bit (b mod 32) of input word (b div 32), with words taken in arrival order. Bit 0 is the mode (0 = lossless, 1 = lossy). Bits 1..7, 8..14 and 15..21 hold the byte offsets, LSB first, where lanes 1, 2 and 3 start. Lane 0 starts at bit 22.
- R4: A codeword is read in increasing bit address, and its first bit is its MSB. A table entry of length L (1..8, where L = 0 means the entry is unused) matches when the next L bits equal the low L bits of the entry's code. A lane's next codeword begins directly after the one it just decoded.
- R5: In mode 0, every lane uses bank 0 and returns the stored symbol unchanged.
- R6: In mode 1, every lane uses bank 1 and returns the stored symbol with its low 4 bits set to zero.
- R7: Output symbol i (0..63) is symbol number i div 4 of lane i mod 4.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sym` stay unchanged. `out_last` is high only on symbol 63.
- R9: `done` is high for exactly the one cycle after symbol 63 is taken, and `in_ready` is high in that same cycle.
- R10: A table write to one bank leaves the other bank's decoding unchanged.
- R11: While a block is decoding or draining, `in_ready` is low. Any input words offered then are ignored and do not disturb the current block or the next one.
- R12: A lane whose sub-stream ends exactly at the last bit of the block decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed word offered |
| in_ready | output | 1 | Block buffer accepting words |
| in_data | input | 32 | Compressed word; bit k is block bit 32w+k |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_bank | input | 1 | 0 = lossless bank, 1 = lossy bank |
| tbl_idx | input | 4 | Entry number |
| tbl_len | input | 4 | Code length, 0 = unused |
| tbl_code | input | 8 | Code, right-aligned |
| tbl_sym | input | 16 | Symbol for the entry |
| out_valid | output | 1 | Decoded symbol available |
| out_ready | input | 1 | Consumer takes the symbol |
| out_sym | output | 16 | Decoded symbol |
| out_last | output | 1 | Marks symbol 63 |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The hardest case to reach from the ports is a lane whose sub-stream runs to the very last bit of the block. In that case the lookup window reaches past the buffer edge. The stimulus builds this case with a bench-side canonical encoder. It sets the fourth pointer to byte 112 and fills that lane with sixteen longest (8-bit) codewords. The random back-pressure and input offered during draining are generated in the same way. Lossy blocks use stored symbols that carry nonzero low bits, so any failure to mask them shows up.

// File: rtl/mhd_pkg.sv
package mhd_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_START = 2'd1,
    ST_DEC   = 2'd2,
    ST_OUT   = 2'd3
  } mhd_state_e;
endpackage

// File: rtl/mhd_table.sv
module mhd_table #(
  parameter int LANES  = 4,
  parameter int N_ENT  = 16,
  parameter int MAX_CL = 8,
  parameter int SYM_W  = 16,
  parameter int Q_BITS = 4,
  localparam int CL_W  = $clog2(MAX_CL + 1),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CL_W-1:0]   wr_len,
  input  logic [MAX_CL-1:0] wr_code,
  input  logic [SYM_W-1:0]  wr_sym,
  input  logic              mode,
  input  logic [MAX_CL-1:0] win     [LANES],
  output logic [CL_W-1:0]   hit_len [LANES],
  output logic [SYM_W-1:0]  hit_sym [LANES]
);
  localparam logic [SYM_W-1:0] Q_MASK = {{(SYM_W-Q_BITS){1'b1}}, {Q_BITS{1'b0}}};

  logic [CL_W-1:0]   t_len  [2][N_ENT];
  logic [MAX_CL-1:0] t_code [2][N_ENT];
  logic [SYM_W-1:0]  t_sym  [2][N_ENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < N_ENT; e++)
          t_len[b][e] <= '0;
    end else if (wr_en) begin
      t_len[wr_bank][wr_idx] <= wr_len;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      t_code[wr_bank][wr_idx] <= wr_code;
      t_sym[wr_bank][wr_idx]  <= wr_sym;
    end
  end

  // The mode bit steers every lane to one bank; the lowest matching entry wins.
  for (genvar l = 0; l < LANES; l++) begin : g_port
    always_comb begin
      hit_len[l] = '0;
      hit_sym[l] = '0;
      for (int e = N_ENT - 1; e >= 0; e--) begin
        if (t_len[mode][e] != '0 &&
            (win[l] >> (CL_W'(MAX_CL) - t_len[mode][e])) == t_code[mode][e]) begin
          hit_len[l] = t_len[mode][e];
          hit_sym[l] = mode ? (t_sym[mode][e] & Q_MASK) : t_sym[mode][e];
        end
      end
    end
  end
endmodule

// File: rtl/mhd_lane.sv
module mhd_lane #(
  parameter int BLK_BITS = 1024,
  parameter int MAX_CL   = 8,
  parameter int SYM_W    = 16,
  parameter int PER_LANE = 16,
  localparam int POS_W   = $clog2(BLK_BITS + 1),
  localparam int BIT_AW  = $clog2(BLK_BITS),
  localparam int CL_W    = $clog2(MAX_CL + 1),
  localparam int RD_W    = $clog2(PER_LANE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [POS_W-1:0]    start_pos,
  input  logic                step,
  input  logic [BLK_BITS-1:0] blk,
  output logic [MAX_CL-1:0]   win,
  input  logic [CL_W-1:0]     hit_len,
  input  logic [SYM_W-1:0]    hit_sym,
  input  logic [RD_W-1:0]     rd_idx,
  output logic [SYM_W-1:0]    rd_sym
);
  logic [POS_W-1:0] pos;
  logic [RD_W:0]    cnt;
  logic [SYM_W-1:0] mem [PER_LANE];

  // Window of upcoming bits, first stream bit in the MSB; bits past the block read as 0.
  always_comb begin
    for (int j = 0; j < MAX_CL; j++) begin
      logic [POS_W-1:0] a;
      a = pos + POS_W'(j);
      win[MAX_CL-1-j] = (a < POS_W'(BLK_BITS)) ? blk[a[BIT_AW-1:0]] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      cnt <= '0;
    end else if (start) begin
      pos <= start_pos;
      cnt <= '0;
    end else if (step) begin
      pos <= pos + POS_W'(hit_len);
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (step) mem[cnt[RD_W-1:0]] <= hit_sym;
  end

  assign rd_sym = mem[rd_idx];

  // R7: a lane never stores more than its share of the block
  a_r7_lane_quota: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt < (RD_W+1)'(PER_LANE));
endmodule

// File: rtl/mhd_decoder.sv
module mhd_decoder
  import mhd_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int LANES     = 4,
  parameter int SYM_W     = 16,
  parameter int MAX_CL    = 8,
  parameter int N_ENT     = 16,
  parameter int Q_BITS    = 4,
  parameter int IN_W      = 32,
  localparam int CL_W     = $clog2(MAX_CL + 1),
  localparam int IDX_W    = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic              tbl_we,
  input  logic              tbl_bank,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [CL_W-1:0]   tbl_len,
  input  logic [MAX_CL-1:0] tbl_code,
  input  logic [SYM_W-1:0]  tbl_sym,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_sym,
  output logic              out_last,
  output logic              done
);
  localparam int BLK_BITS = BLK_BYTES * 8;
  localparam int PTR_W    = $clog2(BLK_BYTES);
  localparam int HDR_BITS = 1 + (LANES - 1) * PTR_W;
  localparam int SYMS     = BLK_BITS / SYM_W;
  localparam int PER_LANE = SYMS / LANES;
  localparam int POS_W    = $clog2(BLK_BITS + 1);
  localparam int WORDS    = BLK_BITS / IN_W;
  localparam int WCNT_W   = $clog2(WORDS);
  localparam int OCNT_W   = $clog2(SYMS);
  localparam int LSEL_W   = $clog2(LANES);
  localparam int RD_W     = $clog2(PER_LANE);

  mhd_state_e        state;
  logic [WCNT_W-1:0] wcnt;
  logic [RD_W-1:0]   scnt;
  logic [OCNT_W-1:0] ocnt;
  logic              mode_q;
  logic              done_q;
  logic [BLK_BITS-1:0] blk;

  logic [MAX_CL-1:0] win       [LANES];
  logic [CL_W-1:0]   hit_len   [LANES];
  logic [SYM_W-1:0]  hit_sym   [LANES];
  logic [SYM_W-1:0]  rd_sym    [LANES];
  logic [POS_W-1:0]  start_pos [LANES];

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_OUT);
  assign out_last  = out_valid && (ocnt == OCNT_W'(SYMS - 1));
  assign out_sym   = rd_sym[ocnt[LSEL_W-1:0]];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      wcnt   <= '0;
      scnt   <= '0;
      ocnt   <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_LOAD: if (in_valid) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCNT_W'(WORDS - 1)) state <= ST_START;
        end
        ST_START: begin
          mode_q <= blk[0];
          scnt   <= '0;
          state  <= ST_DEC;
        end
        ST_DEC: begin
          scnt <= scnt + 1'b1;
          if (scnt == RD_W'(PER_LANE - 1)) begin
            ocnt  <= '0;
            state <= ST_OUT;
          end
        end
        ST_OUT: if (out_ready) begin
          ocnt <= ocnt + 1'b1;
          if (ocnt == OCNT_W'(SYMS - 1)) begin
            done_q <= 1'b1;
            state  <= ST_LOAD;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_LOAD && in_valid) blk[wcnt*IN_W +: IN_W] <= in_data;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_first
      assign start_pos[l] = POS_W'(HDR_BITS);
    end else begin : g_ptr
      assign start_pos[l] = POS_W'({blk[1 + (l-1)*PTR_W +: PTR_W], 3'b000});
    end

    mhd_lane #(
      .BLK_BITS(BLK_BITS), .MAX_CL(MAX_CL), .SYM_W(SYM_W), .PER_LANE(PER_LANE)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .start(state == ST_START), .start_pos(start_pos[l]),
      .step(state == ST_DEC), .blk(blk),
      .win(win[l]), .hit_len(hit_len[l]), .hit_sym(hit_sym[l]),
      .rd_idx(ocnt[OCNT_W-1:LSEL_W]), .rd_sym(rd_sym[l])
    );
  end

  mhd_table #(
    .LANES(LANES), .N_ENT(N_ENT), .MAX_CL(MAX_CL), .SYM_W(SYM_W), .Q_BITS(Q_BITS)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_bank(tbl_bank), .wr_idx(tbl_idx),
    .wr_len(tbl_len), .wr_code(tbl_code), .wr_sym(tbl_sym),
    .mode(mode_q), .win(win), .hit_len(hit_len), .hit_sym(hit_sym)
  );

  // R8: a stalled symbol is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));
  // R9: completion pulse follows the final transfer
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));
  // R11: loading and draining never overlap
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R2: the buffer closes only on an accepted word
  a_r2_close_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
endmodule

// File: tb/tb_mhd_decoder.sv
module tb_mhd_decoder;
  localparam int CLKP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLKP/2) clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        tbl_we = 1'b0, tbl_bank = 1'b0;
  logic [3:0]  tbl_idx = '0, tbl_len = '0;
  logic [7:0]  tbl_code = '0;
  logic [15:0] tbl_sym = '0;
  logic        out_valid, out_ready = 1'b0, out_last, done;
  logic [15:0] out_sym;

  mhd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_bank(tbl_bank), .tbl_idx(tbl_idx), .tbl_len(tbl_len),
    .tbl_code(tbl_code), .tbl_sym(tbl_sym), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_last(out_last), .done(done)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1023:0] blk;
  logic [15:0]   lsym [16];
  logic [15:0]   qsym [16];
  int            clen [16];
  logic [7:0]    ccode [16];
  int            sidx [64];
  bit            cur_mode;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // canonical prefix-free code with lengths 2..8
  task automatic make_codes();
    int lens [16] = '{2,3,3,4,4,5,5,5,6,6,6,7,7,8,8,8};
    int c = 0;
    for (int e = 0; e < 16; e++) begin
      clen[e] = lens[e];
      if (e > 0) c = (c + 1) << (lens[e] - lens[e-1]);
      ccode[e] = 8'(c);
    end
  endtask

  task automatic write_bank(bit bank);
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_bank = bank; tbl_idx = 4'(e);
      tbl_len = 4'(clen[e]); tbl_code = ccode[e];
      tbl_sym = bank ? qsym[e] : lsym[e];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // bench-side encoder; force3 >= 0 pins lane 3's byte pointer
  task automatic build(bit mode, int force3);
    int pos = 22;
    blk = '0;
    blk[0] = mode;
    cur_mode = mode;
    for (int l = 0; l < 4; l++) begin
      if (l > 0) begin
        int byt = (force3 >= 0 && l == 3) ? force3 : (pos + 7) / 8;
        blk[1 + (l-1)*7 +: 7] = 7'(byt);
        pos = byt * 8;
      end
      for (int k = 0; k < 16; k++) begin
        int e = sidx[k*4 + l];
        for (int j = 0; j < clen[e]; j++) blk[pos + j] = ccode[e][clen[e]-1-j];
        pos += clen[e];
      end
    end
  endtask

  task automatic send_block();
    for (int w = 0; w < 32; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = blk[w*32 +: 32];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "in_ready after 32 words", {31'd0, in_ready}, 32'd0);
  endtask

  function automatic logic [15:0] expect_sym(int i);
    return cur_mode ? (qsym[sidx[i]] & 16'hFFF0) : lsym[sidx[i]];
  endfunction

  task automatic recv_block(string req, bit bp, bit junk);
    int n = 0;
    bit stalled = 1'b0;
    logic [15:0] held = '0;
    if (junk) begin
      in_valid = 1'b1;
      in_data = 32'hDEAD_BEEF;
    end
    while (n < 64) begin
      @(negedge clk);
      if (stalled) begin
        chk("R8", "valid held", {31'd0, out_valid}, 32'd1);
        chk("R8", "symbol held", {16'd0, out_sym}, {16'd0, held});
      end
      if (junk) chk("R11", "in_ready low while busy", {31'd0, in_ready}, 32'd0);
      out_ready = bp ? 1'($urandom_range(0, 2) != 0) : 1'b1;
      stalled = out_valid && !out_ready;
      held = out_sym;
      if (out_valid && out_ready) begin
        chk(req, $sformatf("symbol %0d", n), {16'd0, out_sym}, {16'd0, expect_sym(n)});
        if (n == 63 || out_last) chk("R8", "out_last position", {31'd0, out_last}, {31'd0, 1'(n == 63)});
        n++;
        if (n == 64) in_valid = 1'b0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9", "done pulse", {31'd0, done}, 32'd1);
    chk("R9", "in_ready with done", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R9", "done drops", {31'd0, done}, 32'd0);
  endtask

  task automatic rand_syms(int lo, int hi);
    for (int i = 0; i < 64; i++) sidx[i] = $urandom_range(lo, hi);
  endtask

  task automatic t_reset();
    chk("R1", "in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_lossless();  // R5 R3 R4 R7
    rand_syms(0, 15);
    build(1'b0, -1);
    send_block();
    recv_block("R5", 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) sidx[i] = i % 16;
    build(1'b0, -1);
    send_block();
    recv_block("R7", 1'b0, 1'b0);
  endtask

  task automatic t_lossy();  // R6
    rand_syms(0, 15);
    build(1'b1, -1);
    send_block();
    recv_block("R6", 1'b0, 1'b0);
  endtask

  task automatic t_backpressure();  // R8
    rand_syms(0, 15);
    build(1'b0, -1);
    send_block();
    recv_block("R8", 1'b1, 1'b0);
  endtask

  task automatic t_tight_end();  // R12: lane 3 ends on the last block bit
    rand_syms(0, 15);
    for (int k = 0; k < 16; k++) sidx[k*4 + 3] = 13 + (k % 3);
    build(1'b1, 112);
    send_block();
    recv_block("R12", 1'b0, 1'b0);
  endtask

  task automatic t_ignored_input();  // R11
    rand_syms(0, 15);
    build(1'b0, -1);
    send_block();
    recv_block("R11", 1'b1, 1'b1);
    rand_syms(0, 15);
    build(1'b1, -1);
    send_block();
    recv_block("R11", 1'b0, 1'b0);
  endtask

  task automatic t_bank_isolation();  // R10
    rand_syms(0, 15);
    build(1'b1, -1);
    for (int e = 0; e < 16; e++) lsym[e] = ~lsym[e];
    write_bank(1'b0);
    send_block();
    recv_block("R10", 1'b0, 1'b0);
    build(1'b0, -1);
    send_block();
    recv_block("R10", 1'b0, 1'b0);
  endtask

  initial begin
    make_codes();
    for (int e = 0; e < 16; e++) begin
      lsym[e] = 16'($urandom);
      qsym[e] = 16'($urandom) | 16'h0005;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    write_bank(1'b0);
    write_bank(1'b1);
    t_lossless();
    t_lossy();
    t_backpressure();
    t_tight_end();
    t_ignored_input();
    t_bank_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule